// File: doc/BRIEF.md
# Two-Wire Bus Fault Monitor

This block watches the clock and data lines of a two-wire serial bus, with both lines already synchronized to the local clock. From the edges of those lines it tracks where a transfer stands: whether a frame is open, and which of the nine clock periods of a byte (eight data bits, then the acknowledge slot) is under way. It flags three kinds of protocol fault. The first is a start condition in a bit position where none is allowed. The second is a stop condition in such a position. The third is a clock period in which the local transmitter releases the data line but the line reads low.

Any fault sets a sticky bus-error flag that only software clears. If the local master is active, a fault also produces a one-cycle abort pulse, which the surrounding controller uses to drop master mode. The bit tracker does not stop on a fault. A drive conflict leaves the count untouched. A misplaced start restarts the count in the same way a legal start does. This lets the slave address match go on looking at the incoming address after the local master has lost the bus. A bus-busy flag follows start and stop conditions.

Top module: `twi_fault_monitor`

## Requirements
- R1: A start is the data line falling while the clock line stays high. A stop is the data line rising while the clock line stays high. `bus_busy_o` goes high one clock after a start is sampled and low one clock after a stop is sampled.
- R2: A start is illegal when it appears during the clock-high time of bit position 1 to 8 of an open frame. An illegal start sets `bus_err_o` one clock after it is sampled.
- R3: A stop is illegal when it appears during the clock-high time of bit position 1 to 8 of an open frame. An illegal stop sets `bus_err_o` one clock after it is sampled.
- R4: Some start or stop conditions raise no error. This covers one at bit position 0 (a repeated start or a normal stop), one that comes before the first clock rise after a start, and one seen while idle after a stop.
- R5: A drive conflict occurs on a clock rising edge when three things hold together: `sda_own_i`=1, `sda_drive_i`=1 (released) and the data line reads 0. A conflict sets `bus_err_o` one clock later. With `sda_drive_i`=0, with `sda_own_i`=0, or with the line reading 1, no error is raised.
- R6: `bus_err_o` stays set until `err_clr_i` is sampled high, and then clears one clock later. A fault sampled in the same cycle as the clear leaves the flag set.
- R7: `master_abort_o` is a single-cycle pulse. It is high in the cycle after a fault is sampled while `master_i`=1. A fault sampled while `master_i`=0 produces no pulse.
- R8: The first clock rise after a start is bit position 0, and `bit_idx_o` then reads 0. Each later rise adds one, and the count wraps from 8 back to 0. `bit_valid_o` is high from that first rise until a stop.
- R9: A drive conflict does not disturb the bit position. An illegal start restarts the tracker in the same way as a legal start, so the next rise is position 0 with `bit_valid_o`=1. An illegal stop closes the frame, so `bit_valid_o` and `bus_busy_o` go low.
- R10: While reset is held, `bus_err_o`, `master_abort_o`, `bus_busy_o` and `bit_valid_o` are 0, and `bit_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized clock line level |
| sda_i | input | 1 | Synchronized data line level |
| sda_drive_i | input | 1 | Value the local transmitter drives on the data line (1 = released) |
| sda_own_i | input | 1 | Local transmitter owns the data line during this bit |
| master_i | input | 1 | Local master mode is active |
| err_clr_i | input | 1 | Software clear of the bus-error flag |
| bus_err_o | output | 1 | Sticky bus-error flag |
| master_abort_o | output | 1 | One-cycle pulse requesting exit from master mode |
| bus_busy_o | output | 1 | Bus held between a start and a stop |
| bit_valid_o | output | 1 | Bit position is valid (frame open, first rise seen) |
| bit_idx_o | output | 4 | Current bit position, 0 to 8 |

## Verification
Two functions can land on the same clock edge. One is the software clear of the error flag. The other is the detection of a new fault, for example a drive conflict on a clock rising edge. The bench raises `err_clr_i` in exactly the cycle in which the clock line rises while the local transmitter releases a line that reads low. It then requires the error flag to stay set and the bit position to advance. The bench also sweeps a start and a stop across every bit position from 0 to 8. For each position the expected error is computed as "position is not zero", and the restart or idle state of the tracker is checked after each condition.

// File: rtl/twi_fm_pkg.sv
package twi_fm_pkg;

  // Events decoded from one pair of line samples.
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } line_ev_t;

  // Next bit position after a clock rise; wraps past the acknowledge slot.
  function automatic int phase_step(input int idx, input int last);
    return (idx >= last) ? 0 : idx + 1;
  endfunction

  // A start or stop is illegal once a bit past position 0 is under way.
  function automatic logic in_fault_window(input logic framed, input logic armed,
                                           input int idx);
    return framed && armed && (idx != 0);
  endfunction

endpackage

// File: rtl/twi_line_events.sv
module twi_line_events
  import twi_fm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output line_ev_t ev_o
);

  logic scl_q, sda_q;

  // Lines idle high, so reset the history high to avoid bogus edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic scl_held;
  assign scl_held = scl_q & scl_i;

  always_comb begin
    ev_o.start    = scl_held &  sda_q & ~sda_i;
    ev_o.stop     = scl_held & ~sda_q &  sda_i;
    ev_o.scl_rise = ~scl_q & scl_i;
  end

  // R1: start and stop exclude each other and a clock edge.
  p_ev_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_o.start, ev_o.stop, ev_o.scl_rise}));

endmodule

// File: rtl/twi_bit_phase.sv
module twi_bit_phase
  import twi_fm_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDX_W     = $clog2(DATA_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_ev_t         ev_i,
  output logic             framed_o,
  output logic             armed_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             window_o
);

  logic             framed_q, armed_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      framed_q <= 1'b0;
      armed_q  <= 1'b0;
      idx_q    <= '0;
    end else if (ev_i.start) begin
      // Legal or not, a start reopens the frame so address matching resumes.
      framed_q <= 1'b1;
      armed_q  <= 1'b0;
      idx_q    <= '0;
    end else if (ev_i.stop) begin
      framed_q <= 1'b0;
      armed_q  <= 1'b0;
      idx_q    <= '0;
    end else if (ev_i.scl_rise && framed_q) begin
      armed_q <= 1'b1;
      if (armed_q) idx_q <= IDX_W'(phase_step(int'(idx_q), DATA_BITS));
      else         idx_q <= '0;
    end
  end

  assign framed_o = framed_q;
  assign armed_o  = armed_q;
  assign idx_o    = idx_q;
  assign window_o = in_fault_window(framed_q, armed_q, int'(idx_q));

  // R8: position never leaves 0..DATA_BITS.
  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) <= DATA_BITS);

  // R9: any start leaves an open, unarmed frame.
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.start |=> (framed_q && !armed_q && idx_q == '0));

  // R9: a stop closes the frame.
  p_stop_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.stop |=> (!framed_q && !armed_q));

  // R8: a rise within an armed frame advances the position.
  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.scl_rise && framed_q && armed_q && int'(idx_q) < DATA_BITS)
      |=> int'(idx_q) == int'($past(idx_q)) + 1);

endmodule

// File: rtl/twi_fault_core.sv
module twi_fault_core
  import twi_fm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  line_ev_t ev_i,
  input  logic     window_i,
  input  logic     sda_i,
  input  logic     sda_drive_i,
  input  logic     sda_own_i,
  input  logic     master_i,
  input  logic     err_clr_i,
  output logic     bus_err_o,
  output logic     master_abort_o,
  output logic     bus_busy_o
);

  // Named fault events for the assertions.
  logic bad_start, bad_stop, conflict, fault;
  assign bad_start = ev_i.start & window_i;
  assign bad_stop  = ev_i.stop  & window_i;
  assign conflict  = ev_i.scl_rise & sda_own_i & sda_drive_i & ~sda_i;
  assign fault     = bad_start | bad_stop | conflict;

  logic err_q, abort_q, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      // A new fault outranks a clear in the same cycle.
      if (fault)          err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
      abort_q <= fault & master_i;
      if (ev_i.start)     busy_q <= 1'b1;
      else if (ev_i.stop) busy_q <= 1'b0;
    end
  end

  assign bus_err_o      = err_q;
  assign master_abort_o = abort_q;
  assign bus_busy_o     = busy_q;

  // R1: busy follows start and stop.
  p_busy_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.start |=> busy_q);
  p_busy_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.stop |=> !busy_q);

  // R2, R3: misplaced conditions raise the flag.
  p_bad_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_start || bad_stop) |=> err_q);

  // R5: a conflict raises the flag.
  p_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> err_q);

  // R6: the flag holds until cleared.
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr_i) |=> err_q);

  // R7: an abort comes only with the flag and lasts one cycle.
  p_abort_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> err_q);
  p_abort_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> $past(master_i));

endmodule

// File: rtl/twi_fault_monitor.sv
module twi_fault_monitor
  import twi_fm_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDX_W     = $clog2(DATA_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             sda_drive_i,
  input  logic             sda_own_i,
  input  logic             master_i,
  input  logic             err_clr_i,
  output logic             bus_err_o,
  output logic             master_abort_o,
  output logic             bus_busy_o,
  output logic             bit_valid_o,
  output logic [IDX_W-1:0] bit_idx_o
);

  line_ev_t ev;
  logic     framed, armed, window;

  twi_line_events u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  twi_bit_phase #(
    .DATA_BITS (DATA_BITS),
    .IDX_W     (IDX_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev),
    .framed_o (framed),
    .armed_o  (armed),
    .idx_o    (bit_idx_o),
    .window_o (window)
  );

  twi_fault_core u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_i           (ev),
    .window_i       (window),
    .sda_i          (sda_i),
    .sda_drive_i    (sda_drive_i),
    .sda_own_i      (sda_own_i),
    .master_i       (master_i),
    .err_clr_i      (err_clr_i),
    .bus_err_o      (bus_err_o),
    .master_abort_o (master_abort_o),
    .bus_busy_o     (bus_busy_o)
  );

  assign bit_valid_o = framed & armed;

  // R10: outputs quiet while reset is held.
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r10: assert (!bus_err_o && !master_abort_o && !bus_busy_o && !bit_valid_o);
    end
  end

endmodule

// File: tb/twi_fault_monitor_tb.sv
module twi_fault_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       drv = 1'b1, own = 1'b0, mst = 1'b1, clr = 1'b0;
  logic       err, abrt, busy, valid;
  logic [3:0] idx;
  int         n_chk = 0, n_fail = 0;
  int         bidx = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  twi_fault_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_drive_i(drv), .sda_own_i(own), .master_i(mst), .err_clr_i(clr),
    .bus_err_o(err), .master_abort_o(abrt), .bus_busy_o(busy),
    .bit_valid_o(valid), .bit_idx_o(idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One bus step per clock: drive on the falling edge, look one clock later.
  task automatic step(input logic s, input logic d);
    scl = s; sda = d;
    @(negedge clk);
  endtask

  function automatic int next_pos(input int p);
    return (p + 1) % 9;
  endfunction

  // Start (mode 0) or stop (mode 1) during the high time of bit position k.
  task automatic run_cond(input int mode, input int k);
    logic v;
    step(1, 1); step(1, 0);
    chk("R1 busy after start", busy, 1);
    step(0, 0);
    for (int i = 0; i <= k; i++) begin
      v = (i == k) ? (mode == 0) : logic'(i % 2);
      step(0, v); step(1, v);
      chk("R8 bit position", idx, i);
      chk("R8 position valid", valid, 1);
      if (i < k) step(0, v);
    end
    step(1, logic'(mode));
    chk(mode == 0 ? "R2 start error" : "R3 stop error", err, (k != 0) ? 1 : 0);
    chk("R7 abort pulse", abrt, (k != 0) ? 1 : 0);
    if (mode == 0) chk("R1 busy held", busy, 1);
    else begin
      chk("R1 busy dropped", busy, 0);
      chk("R9 frame closed", valid, 0);
    end
    step(1, logic'(mode));
    chk("R7 abort one cycle", abrt, 0);
    chk("R6 error sticky", err, (k != 0) ? 1 : 0);
    clr = 1'b1; step(1, logic'(mode)); clr = 1'b0;
    chk("R6 error cleared", err, 0);
    if (mode == 0) begin
      step(0, 0); step(1, 0);
      chk("R9 restart position", idx, 0);
      chk("R9 restart valid", valid, 1);
      step(1, 1);
      chk("R4 stop at position 0", err, 0);
      chk("R1 busy after stop", busy, 0);
    end
    step(1, 1);
    chk("R4 idle no error", err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset err", err, 0);
    chk("R10 reset abort", abrt, 0);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset valid", valid, 0);
    chk("R10 reset idx", idx, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int k = 0; k <= 8; k++) run_cond(m, k);

    // Drive conflicts, master active.
    step(1, 1); step(1, 0); step(0, 0);
    own = 1'b1; drv = 1'b1;
    step(0, 0); step(1, 0); bidx = 0;
    chk("R5 conflict error", err, 1);
    chk("R7 conflict abort", abrt, 1);
    chk("R9 position after conflict", idx, bidx);
    step(0, 0);
    clr = 1'b1; step(0, 0); clr = 1'b0;
    chk("R6 clear", err, 0);
    drv = 1'b0;
    step(1, 0); bidx = next_pos(bidx);
    chk("R5 drive low no error", err, 0);
    chk("R8 position", idx, bidx);
    step(0, 0);
    own = 1'b0; drv = 1'b1;
    step(1, 0); bidx = next_pos(bidx);
    chk("R5 not owned no error", err, 0);
    chk("R8 position", idx, bidx);
    own = 1'b1;
    step(0, 0); step(0, 1); step(1, 1); bidx = next_pos(bidx);
    chk("R5 line high no error", err, 0);
    step(0, 1); step(0, 0);
    // Clear and new conflict in the same cycle.
    clr = 1'b1; step(1, 0); clr = 1'b0; bidx = next_pos(bidx);
    chk("R6 fault beats clear", err, 1);
    chk("R9 position after conflict", idx, bidx);
    step(0, 0);
    clr = 1'b1; step(0, 0); clr = 1'b0;
    mst = 1'b0;
    step(1, 0); bidx = next_pos(bidx);
    chk("R5 conflict error", err, 1);
    chk("R7 no abort without master", abrt, 0);
    chk("R8 position", idx, bidx);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule